// File: doc/BRIEF.md
# Miss Status Holding Register File

This block keeps a fixed pool of entries that track outstanding cache misses for a non-blocking cache. Each entry records the line address, the request size in bytes, the issuing thread, a fill flag, an expects-response flag, a live-target flag and a lifecycle state: free, waiting (not yet sent) or busy (sent and awaiting a reply). Waiting entries form an ordered queue. Its head is offered as the next request to send to memory.

A single command port accepts one operation per cycle: allocate, release, issue, resend, promote to head, and squash by thread. Two combinational probes run beside the command port. One finds the lowest-index occupied entry with an exact address. The other finds the oldest waiting entry whose byte range overlaps a probe range. The pool is built with `REQ_ENTRIES + RESERVE - 1` physical entries. The full flag rises while the spare entries are still unused, which leaves headroom for operations that need several entries at once.

Top module: `mshr_file`

## Requirements
- R1: With TOT = REQ_ENTRIES + RESERVE - 1 physical entries, `full` is high exactly when `alloc_count` exceeds TOT - RESERVE. With the defaults (4, 2), this happens after four allocations.
- R2: An allocate that is accepted picks the lowest-index free entry and reports it on `alloc_idx` in the same cycle. At the next edge the entry becomes waiting at the tail of the queue, its target flag is set and `alloc_count` rises by one.
- R3: An allocate while `full` is high raises `alloc_err` in that cycle and changes no entry, count or queue.
- R4: `next_valid` is low when the queue is empty; otherwise `next_idx`, `next_addr` and `next_fill` describe the queue head. `have_pending` always equals `next_valid`.
- R5: `hit_valid`/`hit_idx` report the lowest-index entry, waiting or busy, whose address equals `probe_addr`. `hit_tgt` gives that entry's target flag.
- R6: `ovl_valid`/`ovl_idx` report the waiting entry nearest the queue head whose range [addr, addr+size) intersects [probe_addr, probe_addr+probe_size).
- R7: Issue on a waiting entry removes it from the queue. If the entry expects a response it becomes busy and `busy_count` rises by one. If it does not, the entry is freed and `alloc_count` falls by one.
- R8: Resend on a busy entry puts it at the head of the queue as waiting and lowers `busy_count` by one. Resend on any other entry has no effect.
- R9: Promote on a waiting entry moves it to the queue head and keeps the order of the others. Promote on a busy or free entry has no effect.
- R10: Squash frees every waiting entry of `cmd_thread` and removes it from the queue. Busy entries of that thread stay allocated and only lose their target flag.
- R11: Release frees an occupied entry, removes it from the queue if present, lowers `alloc_count` and, if the entry was busy, `busy_count`. Release of a free entry has no effect.
- R12: `cmd_op` encodings: 0 idle, 1 allocate, 2 release, 3 issue, 4 resend, 5 promote, 6 squash. State changes take effect at the rising edge after the command.
- R13: After reset every entry is free, both counts are zero, and `full`, `next_valid` and `hit_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_op | input | 3 | Command code (R12) |
| cmd_idx | input | IW | Target entry for release/issue/resend/promote |
| cmd_addr | input | AW | Line address for allocate |
| cmd_size | input | SW | Request size in bytes for allocate |
| cmd_thread | input | TW | Thread for allocate and squash |
| cmd_fill | input | 1 | Fill flag for allocate |
| cmd_resp | input | 1 | Expects-response flag for allocate |
| alloc_idx | output | IW | Entry an allocate would take this cycle |
| alloc_err | output | 1 | Allocate attempted while full |
| full | output | 1 | Pool full for new allocations |
| alloc_count | output | CW | Occupied entries |
| busy_count | output | CW | Entries in service |
| have_pending | output | 1 | Queue not empty |
| next_valid | output | 1 | Queue head valid |
| next_idx | output | IW | Queue head entry |
| next_addr | output | AW | Queue head address |
| next_fill | output | 1 | Queue head fill flag |
| probe_addr | input | AW | Probe address for both lookups |
| probe_size | input | SW | Probe length for range lookup |
| hit_valid | output | 1 | Address match found |
| hit_idx | output | IW | Matching entry |
| hit_tgt | output | 1 | Target flag of matching entry |
| ovl_valid | output | 1 | Range overlap found |
| ovl_idx | output | IW | Oldest overlapping waiting entry |

## Verification
The lookups are combinational and read the state held before the edge, so a probe that falls in the same cycle as a command on the probed entry must still see the old entry. The bench holds `probe_addr` on an entry while issuing that entry without a response. It expects a hit during the command cycle and a miss after the edge. In the same way it fires an allocate while the pool is full and judges, in the cycle and after it, that the error flag rose and that counts, queue head and probes are unchanged.

// File: rtl/mshr_pkg.sv
// Shared types for the miss status holding register file.
// Assumes command codes are stable for one clock per command.
package mshr_pkg;
    typedef enum logic [2:0] {
        OP_IDLE   = 3'd0,
        OP_ALLOC  = 3'd1,
        OP_FREE   = 3'd2,
        OP_ISSUE  = 3'd3,
        OP_RESEND = 3'd4,
        OP_FRONT  = 3'd5,
        OP_SQUASH = 3'd6
    } mshr_op_e;

    typedef enum logic [1:0] {
        ST_FREE = 2'd0,
        ST_WAIT = 2'd1,
        ST_BUSY = 2'd2
    } mshr_st_e;
endpackage

// File: rtl/mshr_pick.sv
// Lowest-index priority picker.
// Assumes N fits in IW bits; idx is zero when nothing is requested.
module mshr_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Scan from the top so the lowest set bit wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/mshr_order.sv
// Age-ordered queue of entry indices for waiting entries.
// Each cycle it removes the entries flagged in drop (by entry index),
// compacts the survivors in order, then inserts at most one index at the
// head or the tail. Assumes the caller never pushes an index already present.
module mshr_order #(
    parameter int N  = 4,
    parameter int IW = 2,
    parameter int CW = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         drop,
    input  logic                 push_front,
    input  logic                 push_back,
    input  logic [IW-1:0]        push_idx,
    output logic [N-1:0][IW-1:0] ord,
    output logic [CW-1:0]        cnt
);
    logic [N-1:0][IW-1:0] ord_n;
    logic [CW-1:0]        cnt_n;

    // Compact survivors, then apply the single insertion.
    always_comb begin
        int j;
        ord_n = '0;
        j     = 0;
        for (int i = 0; i < N; i++) begin
            if (CW'(i) < cnt && !drop[ord[i]]) begin
                ord_n[j] = ord[i];
                j++;
            end
        end
        if (push_front && j < N) begin
            for (int i = N - 1; i > 0; i--) ord_n[i] = ord_n[i-1];
            ord_n[0] = push_idx;
            j++;
        end else if (push_back && j < N) begin
            ord_n[j] = push_idx;
            j++;
        end
        cnt_n = CW'(j);
    end

    // Hold the queue contents and its length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ord <= '0;
            cnt <= '0;
        end else begin
            ord <= ord_n;
            cnt <= cnt_n;
        end
    end
endmodule

// File: rtl/mshr_file.sv
// Miss status holding register file: fixed pool of miss entries with an
// ordered queue of waiting entries, exact and range lookups, and
// thread squash. One command per cycle; lookups are combinational over
// the registered state. Assumes cmd_idx names a real entry when used.
module mshr_file #(
    parameter  int REQ_ENTRIES = 4,
    parameter  int RESERVE     = 2,
    parameter  int AW          = 16,
    parameter  int SW          = 4,
    parameter  int TW          = 2,
    localparam int TOT         = REQ_ENTRIES + RESERVE - 1,
    localparam int IW          = (TOT > 1) ? $clog2(TOT) : 1,
    localparam int CW          = $clog2(TOT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    cmd_op,
    input  logic [IW-1:0] cmd_idx,
    input  logic [AW-1:0] cmd_addr,
    input  logic [SW-1:0] cmd_size,
    input  logic [TW-1:0] cmd_thread,
    input  logic          cmd_fill,
    input  logic          cmd_resp,
    output logic [IW-1:0] alloc_idx,
    output logic          alloc_err,
    output logic          full,
    output logic [CW-1:0] alloc_count,
    output logic [CW-1:0] busy_count,
    output logic          have_pending,
    output logic          next_valid,
    output logic [IW-1:0] next_idx,
    output logic [AW-1:0] next_addr,
    output logic          next_fill,
    input  logic [AW-1:0] probe_addr,
    input  logic [SW-1:0] probe_size,
    output logic          hit_valid,
    output logic [IW-1:0] hit_idx,
    output logic          hit_tgt,
    output logic          ovl_valid,
    output logic [IW-1:0] ovl_idx
);
    import mshr_pkg::*;

    mshr_st_e      st_q   [TOT];
    logic [AW-1:0] addr_q [TOT];
    logic [SW-1:0] size_q [TOT];
    logic [TW-1:0] thr_q  [TOT];
    logic          fill_q [TOT];
    logic          resp_q [TOT];
    logic          tgt_q  [TOT];

    mshr_op_e             op;
    logic                 idx_ok;
    mshr_st_e             sel_st;
    logic                 sel_resp;
    logic [TOT-1:0]       free_vec, kill_vec, strip_vec, match_vec, pos_vec;
    logic [TOT-1:0]       drop;
    logic                 push_front, push_back;
    logic [IW-1:0]        push_idx;
    logic                 free_ok, do_alloc;
    logic [TOT-1:0][IW-1:0] ord;
    logic [CW-1:0]        qcnt;
    logic [IW-1:0]        ovl_pos;
    logic [CW-1:0]        alloc_n, busy_n;

    assign op       = mshr_op_e'(cmd_op);
    assign idx_ok   = 32'(cmd_idx) < TOT;
    assign sel_st   = idx_ok ? st_q[cmd_idx] : ST_FREE;
    assign sel_resp = idx_ok ? resp_q[cmd_idx] : 1'b0;

    // Per-entry vectors: free slots, squash victims, exact matches.
    always_comb begin
        for (int i = 0; i < TOT; i++) begin
            free_vec[i]  = (st_q[i] == ST_FREE);
            kill_vec[i]  = (op == OP_SQUASH) && (thr_q[i] == cmd_thread) && (st_q[i] == ST_WAIT);
            strip_vec[i] = (op == OP_SQUASH) && (thr_q[i] == cmd_thread) && (st_q[i] == ST_BUSY);
            match_vec[i] = (st_q[i] != ST_FREE) && (addr_q[i] == probe_addr);
        end
    end

    mshr_pick #(.N(TOT), .IW(IW)) u_free_pick (.req(free_vec), .found(free_ok), .idx(alloc_idx));

    assign full      = alloc_count > CW'(TOT - RESERVE);
    assign do_alloc  = (op == OP_ALLOC) && !full && free_ok;
    assign alloc_err = (op == OP_ALLOC) && full;

    // Decode the command into queue edits and count changes.
    always_comb begin
        drop       = '0;
        push_front = 1'b0;
        push_back  = 1'b0;
        push_idx   = cmd_idx;
        alloc_n    = alloc_count;
        busy_n     = busy_count;
        case (op)
            OP_ALLOC: if (do_alloc) begin
                push_back = 1'b1;
                push_idx  = alloc_idx;
                alloc_n   = alloc_count + 1'b1;
            end
            OP_FREE: if (sel_st != ST_FREE) begin
                drop[cmd_idx] = 1'b1;
                alloc_n       = alloc_count - 1'b1;
                if (sel_st == ST_BUSY) busy_n = busy_count - 1'b1;
            end
            OP_ISSUE: if (sel_st == ST_WAIT) begin
                drop[cmd_idx] = 1'b1;
                if (sel_resp) busy_n  = busy_count + 1'b1;
                else          alloc_n = alloc_count - 1'b1;
            end
            OP_RESEND: if (sel_st == ST_BUSY) begin
                push_front = 1'b1;
                busy_n     = busy_count - 1'b1;
            end
            OP_FRONT: if (sel_st == ST_WAIT) begin
                drop[cmd_idx] = 1'b1;
                push_front    = 1'b1;
            end
            OP_SQUASH: begin
                drop    = kill_vec;
                alloc_n = alloc_count - CW'($countones(kill_vec));
            end
            default: ;
        endcase
    end

    mshr_order #(.N(TOT), .IW(IW), .CW(CW)) u_order (
        .clk(clk), .rst_n(rst_n), .drop(drop), .push_front(push_front),
        .push_back(push_back), .push_idx(push_idx), .ord(ord), .cnt(qcnt)
    );

    // Update entry state and fields for the current command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TOT; i++) begin
                st_q[i]   <= ST_FREE;
                addr_q[i] <= '0;
                size_q[i] <= '0;
                thr_q[i]  <= '0;
                fill_q[i] <= 1'b0;
                resp_q[i] <= 1'b0;
                tgt_q[i]  <= 1'b0;
            end
        end else begin
            for (int i = 0; i < TOT; i++) begin
                if (do_alloc && alloc_idx == IW'(i)) begin
                    st_q[i]   <= ST_WAIT;
                    addr_q[i] <= cmd_addr;
                    size_q[i] <= cmd_size;
                    thr_q[i]  <= cmd_thread;
                    fill_q[i] <= cmd_fill;
                    resp_q[i] <= cmd_resp;
                    tgt_q[i]  <= 1'b1;
                end
                if (cmd_idx == IW'(i)) begin
                    if (op == OP_FREE) begin
                        st_q[i]  <= ST_FREE;
                        tgt_q[i] <= 1'b0;
                    end
                    if (op == OP_ISSUE && st_q[i] == ST_WAIT) begin
                        st_q[i] <= resp_q[i] ? ST_BUSY : ST_FREE;
                        if (!resp_q[i]) tgt_q[i] <= 1'b0;
                    end
                    if (op == OP_RESEND && st_q[i] == ST_BUSY) st_q[i] <= ST_WAIT;
                end
                if (kill_vec[i]) begin
                    st_q[i]  <= ST_FREE;
                    tgt_q[i] <= 1'b0;
                end
                if (strip_vec[i]) tgt_q[i] <= 1'b0;
            end
        end
    end

    // Hold occupancy and in-service counts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alloc_count <= '0;
            busy_count  <= '0;
        end else begin
            alloc_count <= alloc_n;
            busy_count  <= busy_n;
        end
    end

    mshr_pick #(.N(TOT), .IW(IW)) u_hit_pick (.req(match_vec), .found(hit_valid), .idx(hit_idx));
    assign hit_tgt = hit_valid && tgt_q[hit_idx];

    // Mark queue positions whose entry range intersects the probe range.
    always_comb begin
        for (int p = 0; p < TOT; p++) begin
            pos_vec[p] = (CW'(p) < qcnt)
                && ({1'b0, addr_q[ord[p]]} < ({1'b0, probe_addr} + (AW+1)'(probe_size)))
                && ({1'b0, probe_addr} < ({1'b0, addr_q[ord[p]]} + (AW+1)'(size_q[ord[p]])));
        end
    end

    mshr_pick #(.N(TOT), .IW(IW)) u_ovl_pick (.req(pos_vec), .found(ovl_valid), .idx(ovl_pos));
    assign ovl_idx = ord[ovl_pos];

    assign next_valid   = (qcnt != '0);
    assign have_pending = next_valid;
    assign next_idx     = ord[0];
    assign next_addr    = addr_q[ord[0]];
    assign next_fill    = fill_q[ord[0]];
endmodule

// File: rtl/mshr_file_chk.sv
// Property checker for mshr_file, attached with bind below.
// Assumes cmd_op codes as in mshr_pkg.
module mshr_file_chk #(
    parameter int REQ_ENTRIES = 4,
    parameter int CW          = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    cmd_op,
    input logic          full,
    input logic [CW-1:0] alloc_count,
    input logic [CW-1:0] busy_count,
    input logic          next_valid
);
    p_cap_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        32'(alloc_count) <= REQ_ENTRIES);

    p_busy_le_alloc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_count <= alloc_count);

    p_full_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 3'd1 && full) |=> $stable(alloc_count));

    p_alloc_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 3'd1 && !full) |=> alloc_count == CW'($past(alloc_count) + 1'b1));

    p_queue_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(next_valid) |-> ($past(cmd_op) == 3'd1 || $past(cmd_op) == 3'd4));
endmodule

bind mshr_file mshr_file_chk #(.REQ_ENTRIES(REQ_ENTRIES), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .full(full),
    .alloc_count(alloc_count), .busy_count(busy_count), .next_valid(next_valid)
);

// File: tb/mshr_file_test.sv
`timescale 1ns/1ps
module mshr_file_test;
    localparam int REQ = 4, RES = 2, TOT = REQ + RES - 1;
    localparam int AW = 16, SW = 4, TW = 2, IW = 3, CW = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [IW-1:0] cmd_idx = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic [SW-1:0] cmd_size = '0;
    logic [TW-1:0] cmd_thread = '0;
    logic cmd_fill = 1'b0, cmd_resp = 1'b0;
    logic [IW-1:0] alloc_idx, next_idx, hit_idx, ovl_idx;
    logic alloc_err, full, have_pending, next_valid, next_fill, hit_valid, hit_tgt, ovl_valid;
    logic [CW-1:0] alloc_count, busy_count;
    logic [AW-1:0] next_addr, probe_addr = '0;
    logic [SW-1:0] probe_size = '0;

    int nchk = 0, nerr = 0;
    bit done = 0;
    int c_aidx, c_aerr, c_hit, c_hidx;

    always #2.5 clk = ~clk;

    mshr_file #(.REQ_ENTRIES(REQ), .RESERVE(RES), .AW(AW), .SW(SW), .TW(TW)) uut (.*);

    task automatic chk(string r, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", r, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    task automatic cmd(int op, int idx, int addr, int size, int thr, int resp, int fill = 0);
        @(negedge clk);
        cmd_op = 3'(op); cmd_idx = IW'(idx); cmd_addr = AW'(addr);
        cmd_size = SW'(size); cmd_thread = TW'(thr); cmd_resp = resp[0]; cmd_fill = fill[0];
        #1;
        c_aidx = int'(alloc_idx); c_aerr = int'(alloc_err);
        c_hit = int'(hit_valid); c_hidx = int'(hit_idx);
        @(posedge clk); #1;
        cmd_op = '0;
    endtask

    task automatic probe(int a, int s);
        probe_addr = AW'(a); probe_size = SW'(s); #1;
    endtask

    initial begin
        #(200000 * 5);
        nerr++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        probe(16'h100, 1);
        // R13 reset state
        chk("R13 alloc_count", alloc_count, 0);
        chk("R13 busy_count", busy_count, 0);
        chk("R13 next_valid", next_valid, 0);
        chk("R13 full", full, 0);
        chk("R13 hit_valid", hit_valid, 0);
        chk("R4 have_pending empty", have_pending, 0);

        // R2/R1/R12 fill the usable capacity (code 1 = allocate)
        cmd(1, 0, 16'h100, 8, 0, 1, 1);
        chk("R2 idx0", c_aidx, 0);
        cmd(1, 0, 16'h200, 4, 1, 1);
        chk("R2 idx1", c_aidx, 1);
        cmd(1, 0, 16'h104, 4, 0, 0);
        chk("R2 idx2", c_aidx, 2);
        chk("R1 not full at 3", full, 0);
        cmd(1, 0, 16'h300, 8, 1, 1);
        chk("R2 idx3", c_aidx, 3);
        chk("R2 count 4", alloc_count, 4);
        chk("R1 full at 4", full, 1);

        // R3 allocate while full is ignored
        cmd(1, 0, 16'h700, 4, 2, 1);
        chk("R3 alloc_err", c_aerr, 1);
        chk("R3 count kept", alloc_count, 4);
        chk("R3 head kept", next_idx, 0);
        probe(16'h700, 1);
        chk("R3 no entry written", hit_valid, 0);

        // R4 head of queue
        chk("R4 next_valid", next_valid, 1);
        chk("R4 have_pending", have_pending, 1);
        chk("R4 next_addr", next_addr, 16'h100);
        chk("R4 next_fill", next_fill, 1);

        // R5 exact lookups
        probe(16'h200, 1);
        chk("R5 hit 0x200", hit_valid ? int'(hit_idx) : -1, 1);
        probe(16'h104, 1);
        chk("R5 hit 0x104", hit_valid ? int'(hit_idx) : -1, 2);
        probe(16'h105, 1);
        chk("R5 miss 0x105", hit_valid, 0);

        // R6 overlap, oldest first
        probe(16'h106, 2);
        chk("R6 overlap oldest", ovl_valid ? int'(ovl_idx) : -1, 0);

        // R9 promote waiting entry 2 (code 5)
        cmd(5, 2, 0, 0, 0, 0);
        chk("R9 promoted head", next_idx, 2);
        chk("R6 overlap follows order", ovl_valid ? int'(ovl_idx) : -1, 2);

        // R7 issue without response, probe in the same cycle (code 3)
        probe(16'h104, 1);
        cmd(3, 2, 0, 0, 0, 0);
        chk("R5 probe during issue sees old", c_hit ? c_hidx : -1, 2);
        chk("R7 freed no-resp", hit_valid, 0);
        chk("R7 count 3", alloc_count, 3);
        chk("R7 busy 0", busy_count, 0);
        chk("R7 head back to 0", next_idx, 0);
        chk("R1 full cleared", full, 0);

        // R7 issue with response
        cmd(3, 0, 0, 0, 0, 0);
        chk("R7 busy 1", busy_count, 1);
        chk("R7 head 1", next_idx, 1);
        probe(16'h106, 2);
        chk("R6 busy entry not overlap", ovl_valid, 0);
        probe(16'h100, 1);
        chk("R5 busy entry hits", hit_valid ? int'(hit_idx) : -1, 0);

        // R9 promote busy entry: no effect
        cmd(5, 0, 0, 0, 0, 0);
        chk("R9 busy promote head", next_idx, 1);
        chk("R9 busy promote busy", busy_count, 1);

        // R8 resend on waiting entry: no effect; then on busy (code 4)
        cmd(4, 1, 0, 0, 0, 0);
        chk("R8 resend waiting busy", busy_count, 1);
        chk("R8 resend waiting head", next_idx, 1);
        cmd(4, 0, 0, 0, 0, 0);
        chk("R8 resend head", next_idx, 0);
        chk("R8 resend busy", busy_count, 0);
        cmd(3, 0, 0, 0, 0, 0);
        chk("R7 reissue busy", busy_count, 1);

        // R2 reuse lowest free slot
        cmd(1, 0, 16'h400, 4, 1, 1);
        chk("R2 reuse idx2", c_aidx, 2);
        chk("R2 tail order", next_idx, 1);

        // R10 squash thread 1 (code 6)
        cmd(6, 0, 0, 0, 1, 0);
        chk("R10 count after squash", alloc_count, 1);
        chk("R10 queue empty", next_valid, 0);
        chk("R4 have_pending follows", have_pending, 0);
        probe(16'h100, 1);
        chk("R10 target before", hit_tgt, 1);
        cmd(6, 0, 0, 0, 0, 0);
        chk("R10 busy kept", alloc_count, 1);
        chk("R10 busy count kept", busy_count, 1);
        chk("R10 target cleared", hit_tgt, 0);
        chk("R10 still hits", hit_valid, 1);

        // R11 release (code 2)
        cmd(2, 0, 0, 0, 0, 0);
        chk("R11 count 0", alloc_count, 0);
        chk("R11 busy 0", busy_count, 0);
        chk("R11 miss", hit_valid, 0);
        cmd(2, 0, 0, 0, 0, 0);
        chk("R11 release free", alloc_count, 0);
        cmd(1, 0, 16'h500, 4, 0, 1);
        cmd(2, 0, 0, 0, 0, 0);
        chk("R11 removed from queue", next_valid, 0);

        // R6 overlap sweep against one entry [0x100,0x108)
        cmd(1, 0, 16'h100, 8, 0, 1);
        for (int off = 0; off < 16; off++) begin
            int p = 16'hFC + off;
            probe(p, 4);
            chk("R6 sweep", ovl_valid, (p < 16'h108 && 16'h100 < p + 4) ? 1 : 0);
        end
        cmd(2, 0, 0, 0, 0, 0);

        // R1/R2/R7/R11 fill, issue, release sweep
        for (int k = 0; k < REQ; k++) begin
            cmd(1, 0, 16'h800 + 16 * k, 4, k % 4, 1);
            chk("R2 sweep idx", c_aidx, k);
            chk("R1 sweep full", full, (k + 1 > TOT - RES) ? 1 : 0);
        end
        for (int k = 0; k < REQ; k++) begin
            chk("R4 sweep head", next_idx, k);
            cmd(3, k, 0, 0, 0, 0);
            chk("R7 sweep busy", busy_count, k + 1);
        end
        chk("R4 sweep empty", next_valid, 0);
        for (int k = 0; k < REQ; k++) begin
            cmd(2, k, 0, 0, 0, 0);
            chk("R11 sweep count", alloc_count, REQ - 1 - k);
            chk("R11 sweep busy", busy_count, REQ - 1 - k);
        end

        finish_run();
    end
endmodule